// File: doc/BRIEF.md
# Serial link bring-up controller

This block brings a point-to-point serial link from power-up to payload traffic. It watches the lock and alignment status of the physical layer, and a per-cycle classification of received idle symbols. From these it reports when the transmit side and the receive side are usable. It then runs a two-phase idle handshake with the far end: first a run of alternating idles, then a run of repeated IDLE1 idles. Payload frames and special commas are released only when the handshake is complete.

One input, `role_master`, picks the role. In the master role the transmitter changes from alternating idles to repeated idles as soon as its own receive side is ready. In the slave role it keeps sending alternating idles until the handshake completes. Any loss of lock or alignment drops the link back to its first waiting state.

The state machine has five states:
- `LB_WAIT_TX` waits for the transmit side. It moves to `LB_WAIT_RX` on `tx_ready`.
- `LB_WAIT_RX` waits for the receive side. It moves to `LB_TOGGLE_RUN` on `rx_ready`.
- `LB_TOGGLE_RUN` counts alternating idles. It moves to `LB_STEADY_RUN` when that run reaches `RUN_LEN`.
- `LB_STEADY_RUN` counts repeated IDLE1 symbols. It moves to `LB_LINKED` when that run reaches `RUN_LEN`.
- `LB_LINKED` carries traffic.

Every state except `LB_WAIT_TX` returns to `LB_WAIT_TX` on link loss.

Symbol kind encoding on `rx_sym_kind` is:
- `2'b00`: data word
- `2'b01`: IDLE1
- `2'b10`: IDLE2
- `2'b11`: special comma

Top module: `link_bringup_ctrl`

## Requirements
- R1: `tx_ready` is a register that goes high one clock edge after every bit of `pll_lock` and every bit of `ser_sync` are high at the same time. It is low otherwise.
- R2: `rx_ready` is a register that goes high one clock edge after three conditions hold together: bit `RX_LANE` of `cdr_lock` is high, `align_found` is high, and `align_pos` is zero. It is low otherwise.
- R3: The machine leaves `LB_WAIT_TX` on the edge after `tx_ready` is high. It leaves `LB_WAIT_RX` on the edge after `rx_ready` is high. No idle run is counted before `LB_TOGGLE_RUN`.
- R4: In `LB_TOGGLE_RUN`, a run counts consecutive valid idles (`2'b01`/`2'b10`), each differing from the previous one. A repeated idle restarts the run at one. A non-idle symbol clears it. Cycles with `rx_sym_valid` low leave the run unchanged. `half_done` rises on the edge after the run reaches `RUN_LEN`.
- R5: In `LB_STEADY_RUN`, a run counts consecutive valid IDLE1 (`2'b01`) symbols. Any other valid symbol clears it. `full_done` rises on the edge after the run reaches `RUN_LEN`. IDLE1 runs received before `half_done` is set never raise `full_done`.
- R6: `tx_idle_steady` (1 = repeated IDLE1, 0 = alternating idles) depends on the role. With `role_master` = 1 it is high from `LB_TOGGLE_RUN` onward. With `role_master` = 0 it is high only in `LB_LINKED`.
- R7: `payload_en` is high only in `LB_LINKED`.
- R8: `rx_data_strobe` pulses for one cycle, one edge after a valid data word (`2'b00`) or comma (`2'b11`) is received in `LB_LINKED`. Such symbols received earlier produce no strobe and do not advance the handshake.
- R9: Suppose any bit of `pll_lock` or `ser_sync` drops in any state past `LB_WAIT_TX`. Or suppose the receive condition of R2 fails in `LB_TOGGLE_RUN`, `LB_STEADY_RUN` or `LB_LINKED`. Then two edges later `half_done`, `full_done`, `payload_en` and `tx_idle_steady` are low, and the machine is back in `LB_WAIT_TX`.
- R10: While `rst` is high at a clock edge, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| pll_lock | input | NUM_QUADS | Transmit PLL lock, one bit per used quad |
| ser_sync | input | NUM_LANES | Serializer sync, one bit per lane |
| cdr_lock | input | NUM_LANES | Receive CDR lock, one bit per lane |
| align_found | input | 1 | Word alignment found on the designated lane |
| align_pos | input | POS_W | Alignment position found |
| rx_sym_valid | input | 1 | A received symbol is present this cycle |
| rx_sym_kind | input | 2 | Received symbol kind |
| tx_ready | output | 1 | Transmit side usable |
| rx_ready | output | 1 | Receive side usable |
| half_done | output | 1 | Alternating-idle phase complete |
| full_done | output | 1 | Repeated-idle phase complete |
| tx_idle_steady | output | 1 | Transmit idle mode select |
| payload_en | output | 1 | Payload and commas enabled |
| rx_data_strobe | output | 1 | Non-idle symbol accepted for payload |

## Verification
The two ready flags follow their inputs after one edge, so the sweeps drive each input combination and sample after a single edge. A run reaching `RUN_LEN` shows on the done flags one edge after the last counted symbol. The bench therefore samples once right after that symbol, expecting no change, and once one edge later, expecting the flag. A loss of lock reaches the done flags two edges after the input drops: one edge for the ready register and one for the state. The checks look at both edges. The receive strobe is sampled exactly one edge after the symbol and again one edge later to confirm that it falls.

// File: rtl/lb_pkg.sv
package lb_pkg;

    typedef enum logic [2:0] {
        LB_WAIT_TX    = 3'd0,
        LB_WAIT_RX    = 3'd1,
        LB_TOGGLE_RUN = 3'd2,
        LB_STEADY_RUN = 3'd3,
        LB_LINKED     = 3'd4
    } lb_state_t;

    typedef enum logic [1:0] {
        SYM_DATA  = 2'b00,
        SYM_IDLE1 = 2'b01,
        SYM_IDLE2 = 2'b10,
        SYM_COMMA = 2'b11
    } lb_sym_t;

    function automatic logic sym_is_idle(input logic [1:0] kind);
        return (kind == SYM_IDLE1) || (kind == SYM_IDLE2);
    endfunction

endpackage

// File: rtl/lb_ready_monitor.sv
module lb_ready_monitor #(
    parameter int NUM_QUADS = 2,
    parameter int NUM_LANES = 4,
    parameter int RX_LANE   = 0,
    parameter int POS_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_QUADS-1:0] pll_lock,
    input  logic [NUM_LANES-1:0] ser_sync,
    input  logic [NUM_LANES-1:0] cdr_lock,
    input  logic                 align_found,
    input  logic [POS_W-1:0]     align_pos,
    output logic                 tx_ready,
    output logic                 rx_ready
);

    logic tx_ok;
    logic rx_ok;

    // R1: every quad PLL and every serializer must report good
    assign tx_ok = (&pll_lock) & (&ser_sync);

    // R2: designated lane locked, aligned at position zero
    assign rx_ok = cdr_lock[RX_LANE] & align_found & (align_pos == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ready <= 1'b0;
            rx_ready <= 1'b0;
        end else begin
            tx_ready <= tx_ok;
            rx_ready <= rx_ok;
        end
    end

endmodule

// File: rtl/lb_run_counter.sv
module lb_run_counter
    import lb_pkg::*;
#(
    parameter int RUN_LEN = 16,
    parameter bit STEADY  = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       sym_valid,
    input  logic [1:0] sym_kind,
    output logic       run_met
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] run_cnt;
    logic [1:0]       prev_kind;
    logic             sym_hit;
    logic             sym_cont;

    generate
        if (STEADY) begin : g_steady
            // repeated IDLE1 only
            assign sym_hit  = (sym_kind == SYM_IDLE1);
            assign sym_cont = sym_hit && (prev_kind == SYM_IDLE1);
        end else begin : g_toggle
            // idle differing from the previous idle
            assign sym_hit  = sym_is_idle(sym_kind);
            assign sym_cont = sym_hit && sym_is_idle(prev_kind)
                              && (sym_kind != prev_kind);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_kind <= SYM_DATA;
        end else if (sym_valid) begin
            prev_kind <= sym_kind;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run_cnt <= '0;
        end else if (sym_valid) begin
            if (!sym_hit) begin
                run_cnt <= '0;
            end else if (sym_cont) begin
                if (run_cnt < CNT_MAX) begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= CNT_W'(1);
            end
        end
    end

    assign run_met = (run_cnt == CNT_MAX);

endmodule

// File: rtl/lb_fsm.sv
module lb_fsm
    import lb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       role_master,
    input  logic       tx_ready,
    input  logic       rx_ready,
    input  logic       toggle_met,
    input  logic       steady_met,
    input  logic       sym_valid,
    input  logic [1:0] sym_kind,
    output lb_state_t  state,
    output logic       half_done,
    output logic       full_done,
    output logic       tx_idle_steady,
    output logic       payload_en,
    output logic       rx_data_strobe
);

    lb_state_t state_next;
    logic      link_lost;

    always_comb begin
        unique case (state)
            LB_WAIT_TX: link_lost = 1'b0;
            LB_WAIT_RX: link_lost = !tx_ready;
            default:    link_lost = !tx_ready || !rx_ready;
        endcase
    end

    always_comb begin
        state_next = state;
        if (link_lost) begin
            state_next = LB_WAIT_TX;
        end else begin
            unique case (state)
                LB_WAIT_TX:    if (tx_ready)   state_next = LB_WAIT_RX;
                LB_WAIT_RX:    if (rx_ready)   state_next = LB_TOGGLE_RUN;
                LB_TOGGLE_RUN: if (toggle_met) state_next = LB_STEADY_RUN;
                LB_STEADY_RUN: if (steady_met) state_next = LB_LINKED;
                LB_LINKED:     state_next = LB_LINKED;
                default:       state_next = LB_WAIT_TX;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LB_WAIT_TX;
        end else begin
            state <= state_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_done      <= 1'b0;
            full_done      <= 1'b0;
            tx_idle_steady <= 1'b0;
            payload_en     <= 1'b0;
            rx_data_strobe <= 1'b0;
        end else begin
            half_done  <= (state_next == LB_STEADY_RUN) || (state_next == LB_LINKED);
            full_done  <= (state_next == LB_LINKED);
            payload_en <= (state_next == LB_LINKED);
            if (role_master) begin
                tx_idle_steady <= (state_next == LB_TOGGLE_RUN)
                               || (state_next == LB_STEADY_RUN)
                               || (state_next == LB_LINKED);
            end else begin
                tx_idle_steady <= (state_next == LB_LINKED);
            end
            rx_data_strobe <= (state == LB_LINKED) && !link_lost && sym_valid
                              && !sym_is_idle(sym_kind);
        end
    end

endmodule

// File: rtl/link_bringup_ctrl.sv
module link_bringup_ctrl
    import lb_pkg::*;
#(
    parameter int NUM_QUADS = 2,
    parameter int NUM_LANES = 4,
    parameter int RX_LANE   = 0,
    parameter int POS_W     = 5,
    parameter int RUN_LEN   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 role_master,
    input  logic [NUM_QUADS-1:0] pll_lock,
    input  logic [NUM_LANES-1:0] ser_sync,
    input  logic [NUM_LANES-1:0] cdr_lock,
    input  logic                 align_found,
    input  logic [POS_W-1:0]     align_pos,
    input  logic                 rx_sym_valid,
    input  logic [1:0]           rx_sym_kind,
    output logic                 tx_ready,
    output logic                 rx_ready,
    output logic                 half_done,
    output logic                 full_done,
    output logic                 tx_idle_steady,
    output logic                 payload_en,
    output logic                 rx_data_strobe
);

    localparam int NUM_PHASES = 2;

    lb_state_t             state;
    logic [NUM_PHASES-1:0] phase_en;
    logic [NUM_PHASES-1:0] phase_met;

    lb_ready_monitor #(
        .NUM_QUADS (NUM_QUADS),
        .NUM_LANES (NUM_LANES),
        .RX_LANE   (RX_LANE),
        .POS_W     (POS_W)
    ) i_ready (
        .clk         (clk),
        .rst         (rst),
        .pll_lock    (pll_lock),
        .ser_sync    (ser_sync),
        .cdr_lock    (cdr_lock),
        .align_found (align_found),
        .align_pos   (align_pos),
        .tx_ready    (tx_ready),
        .rx_ready    (rx_ready)
    );

    assign phase_en[0] = (state == LB_TOGGLE_RUN);
    assign phase_en[1] = (state == LB_STEADY_RUN);

    generate
        for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
            lb_run_counter #(
                .RUN_LEN (RUN_LEN),
                .STEADY  (g == 1)
            ) i_run (
                .clk       (clk),
                .rst       (rst),
                .enable    (phase_en[g]),
                .sym_valid (rx_sym_valid),
                .sym_kind  (rx_sym_kind),
                .run_met   (phase_met[g])
            );
        end
    endgenerate

    lb_fsm i_fsm (
        .clk            (clk),
        .rst            (rst),
        .role_master    (role_master),
        .tx_ready       (tx_ready),
        .rx_ready       (rx_ready),
        .toggle_met     (phase_met[0]),
        .steady_met     (phase_met[1]),
        .sym_valid      (rx_sym_valid),
        .sym_kind       (rx_sym_kind),
        .state          (state),
        .half_done      (half_done),
        .full_done      (full_done),
        .tx_idle_steady (tx_idle_steady),
        .payload_en     (payload_en),
        .rx_data_strobe (rx_data_strobe)
    );

endmodule

// File: rtl/lb_checker.sv
module lb_checker (
    input logic clk,
    input logic rst,
    input logic role_master,
    input logic tx_ready,
    input logic rx_ready,
    input logic half_done,
    input logic full_done,
    input logic tx_idle_steady,
    input logic payload_en,
    input logic rx_data_strobe
);

    p_half_needs_ready_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(half_done) |-> $past(tx_ready && rx_ready));

    p_full_after_half_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(full_done) |-> $past(half_done));

    p_full_implies_half_r5: assert property (@(posedge clk) disable iff (rst)
        full_done |-> half_done);

    p_slave_toggles_r6: assert property (@(posedge clk) disable iff (rst)
        (!role_master && tx_idle_steady) |-> full_done);

    p_master_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (role_master && half_done) |-> tx_idle_steady);

    p_payload_linked_r7: assert property (@(posedge clk) disable iff (rst)
        payload_en |-> half_done);

    p_strobe_linked_r8: assert property (@(posedge clk) disable iff (rst)
        rx_data_strobe |-> $past(payload_en));

    p_loss_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (!tx_ready || !rx_ready) |=>
            (!half_done && !full_done && !payload_en && !tx_idle_steady));

endmodule

bind link_bringup_ctrl lb_checker i_lb_checker (
    .clk            (clk),
    .rst            (rst),
    .role_master    (role_master),
    .tx_ready       (tx_ready),
    .rx_ready       (rx_ready),
    .half_done      (half_done),
    .full_done      (full_done),
    .tx_idle_steady (tx_idle_steady),
    .payload_en     (payload_en),
    .rx_data_strobe (rx_data_strobe)
);

// File: tb/test_link_bringup_ctrl.sv
`timescale 1ns/1ps
module test_link_bringup_ctrl;

    localparam int NQ   = 2;
    localparam int NL   = 4;
    localparam int LANE = 2;
    localparam int PW   = 2;
    localparam int RL   = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          role_master = 1'b0;
    logic [NQ-1:0] pll_lock = '0;
    logic [NL-1:0] ser_sync = '0;
    logic [NL-1:0] cdr_lock = '0;
    logic          align_found = 1'b0;
    logic [PW-1:0] align_pos = '0;
    logic          rx_sym_valid = 1'b0;
    logic [1:0]    rx_sym_kind = 2'b00;
    logic tx_ready, rx_ready, half_done, full_done;
    logic tx_idle_steady, payload_en, rx_data_strobe;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    link_bringup_ctrl #(
        .NUM_QUADS (NQ),
        .NUM_LANES (NL),
        .RX_LANE   (LANE),
        .POS_W     (PW),
        .RUN_LEN   (RL)
    ) i_link_bringup_ctrl (
        .clk            (clk),
        .rst            (rst),
        .role_master    (role_master),
        .pll_lock       (pll_lock),
        .ser_sync       (ser_sync),
        .cdr_lock       (cdr_lock),
        .align_found    (align_found),
        .align_pos      (align_pos),
        .rx_sym_valid   (rx_sym_valid),
        .rx_sym_kind    (rx_sym_kind),
        .tx_ready       (tx_ready),
        .rx_ready       (rx_ready),
        .half_done      (half_done),
        .full_done      (full_done),
        .tx_idle_steady (tx_idle_steady),
        .payload_en     (payload_en),
        .rx_data_strobe (rx_data_strobe)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] kind);
        rx_sym_valid = 1'b1;
        rx_sym_kind  = kind;
        tick();
        rx_sym_valid = 1'b0;
    endtask

    task automatic all_good();
        pll_lock = '1; ser_sync = '1; cdr_lock = '1;
        align_found = 1'b1; align_pos = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pll_lock = '0; ser_sync = '0; cdr_lock = '0;
        align_found = 1'b0; align_pos = '0;
        tick(); tick();
        check(tx_ready | rx_ready | half_done | full_done, 1'b0, "R10 reset flags");
        check(tx_idle_steady | payload_en | rx_data_strobe, 1'b0, "R10 reset controls");
        rst = 1'b0;
    endtask

    task automatic run_role(input logic m);
        role_master = m;
        do_reset();
        all_good();
        tick();
        check(tx_ready, 1'b1, "R1 tx ready after one edge");
        check(rx_ready, 1'b1, "R2 rx ready after one edge");
        check(tx_idle_steady, 1'b0, "R3 still waiting tx");
        tick();
        check(tx_idle_steady, 1'b0, "R3 waiting rx");
        tick();
        check(tx_idle_steady, m, "R6 idle mode on entering toggle phase");
        check(half_done, 1'b0, "R3 no half on entry");
        for (int i = 0; i < 20; i++) send(2'b01);
        tick();
        check(half_done | full_done, 1'b0, "R5 steady idles before half ignored");
        send(2'b00);
        check(rx_data_strobe, 1'b0, "R8 data before link ignored");
        for (int i = 0; i < RL - 1; i++) send(i % 2 == 0 ? 2'b10 : 2'b01);
        tick(); tick();
        check(half_done, 1'b0, "R4 short toggle run");
        for (int i = 0; i < RL; i++) send(i % 2 == 0 ? 2'b10 : 2'b01);
        check(half_done, 1'b0, "R4 half not yet on last symbol edge");
        tick();
        check(half_done, 1'b1, "R4 half after run");
        check(full_done, 1'b0, "R5 full not yet");
        check(tx_idle_steady, m, "R6 idle mode during steady phase");
        send(2'b11);
        check(rx_data_strobe, 1'b0, "R8 comma before link ignored");
        check(full_done, 1'b0, "R8 comma does not advance");
        for (int i = 0; i < RL - 1; i++) send(2'b01);
        tick();
        check(full_done, 1'b0, "R5 short steady run");
        send(2'b10);
        for (int i = 0; i < RL; i++) send(2'b01);
        check(full_done, 1'b0, "R5 full not yet on last symbol edge");
        check(tx_idle_steady, m, "R6 idle mode before link");
        tick();
        check(full_done, 1'b1, "R5 full after run");
        check(payload_en, 1'b1, "R7 payload enabled");
        check(tx_idle_steady, 1'b1, "R6 steady idles when linked");
        send(2'b00);
        check(rx_data_strobe, 1'b1, "R8 data strobe");
        tick();
        check(rx_data_strobe, 1'b0, "R8 strobe one cycle");
        send(2'b01);
        check(rx_data_strobe, 1'b0, "R8 idle no strobe");
        send(2'b11);
        check(rx_data_strobe, 1'b1, "R8 comma strobe");
        if (m) pll_lock[0] = 1'b0;
        else   cdr_lock[LANE] = 1'b0;
        tick();
        check(full_done, 1'b1, "R9 flags hold one edge");
        check(m ? tx_ready : rx_ready, 1'b0, "R9 ready drops");
        tick();
        check(half_done | full_done, 1'b0, "R9 done flags cleared");
        check(payload_en, 1'b0, "R9 payload off");
        check(tx_idle_steady, 1'b0, "R9 back to toggling idles");
        all_good();
        tick(); tick(); tick(); tick();
        check(half_done, 1'b0, "R9 handshake restarts");
        check(tx_idle_steady, m, "R9 restart idle mode");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                n_tests++;
                $display("FAIL watchdog R3: actual timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 sweep: all PLL and serializer combinations, rx side held bad
        for (int v = 0; v < 64; v++) begin
            pll_lock = v[1:0];
            ser_sync = v[5:2];
            tick();
            check(tx_ready, (v[1:0] == 2'b11) && (v[5:2] == 4'hF), "R1 tx sweep");
        end
        pll_lock = '1; ser_sync = '1;
        // R2 sweep: lane locks, alignment flag and position
        for (int v = 0; v < 128; v++) begin
            cdr_lock    = v[3:0];
            align_found = v[4];
            align_pos   = v[6:5];
            tick();
            check(rx_ready, v[LANE] && v[4] && (v[6:5] == 2'b00), "R2 rx sweep");
        end
        run_role(1'b1);
        run_role(1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule